// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the scan timing for a display panel: horizontal and vertical sync, a data-enable strobe, the pixel coordinates of the current active pixel, and a pixel-clock enable derived from the core clock. All timing comes from a small bank of registers behind a synchronous write port with a combinational read port. Horizontal timing is counted in pixels and vertical timing is counted in lines. Each axis runs its active area, then front porch, then sync pulse, then back porch.

The block also produces the colour for each pixel. In normal mode it passes an upstream layer colour through, and falls back to a programmable background colour when no layer covers the pixel. A test mode shows a coordinate ramp, and a colour-bar mode shows eight vertical bars. A two-bit interrupt unit latches a frame-start event (the start of vertical sync) and an underrun event reported by the pixel-fetch path. Both events can be masked.

Timing registers are double-buffered. Software may reprogram them while the raster runs, and the new values take effect at the next frame boundary, so no frame is ever torn.

Top module: `raster_timing_gen`

## Requirements
- R1: The raster runs only when the mode field is non-zero and the enable bit is set. Otherwise `de_o`, `pix_ce_o` and `rgb_o` stay 0, `hsync_o`/`vsync_o` sit at their inactive level (equal to their polarity bit), and the counters are held at 0.
- R2: While the raster runs, `pix_ce_o` is high for one core cycle in every (N+1), where N is the divider register value (register 8, bits DIV_W-1:0).
- R3: Horizontal sequence: active = 16 × block count pixels, then front porch, then sync pulse, then back porch. `hsync_o` is active during the pulse. `de_o` is high only when both axes are in their active areas. `pix_x_o` gives the pixel index within the line while `de_o` is high, and is 0 otherwise.
- R4: The vertical sequence uses the same order counted in lines. The line counter advances on the last pixel of a line, so `vsync_o` changes only at a line start. `pix_y_o` gives the line index while `de_o` is high.
- R5: Polarity register 5: bit 0 makes `hsync_o` active-low, bit 1 makes `vsync_o` active-low, and bit 6 drives `pix_fall_o` (data launched on the falling pixel-clock edge). Polarity changes apply at once.
- R6: Per-axis timing registers (3 = horizontal, 4 = vertical): back porch in bits 31:22, pulse width in bits 21:11, front porch in bits 10:0. Size register 2: line count in bits 31:16, horizontal width divided by 16 in bits XBLK_W-1:0.
- R7: Registers 2, 3, 4 and 8 are staged. A read returns the staged value. The staged value becomes active at the end of a frame while running, and on the next cycle while not running.
- R8: Mode 1 (normal): during `de_o`, `rgb_o` is `layer_rgb_i` when `layer_valid_i` is high, and otherwise the background register 1 (R 23:16, G 15:8, B 7:0).
- R9: Mode 3 shows 8 bars, each 2 × block count pixels wide. From the left, the bars are white, yellow, cyan, green, magenta, red, blue, black.
- R10: Mode 2 shows a ramp during `de_o`: R = x[7:0], G = y[7:0], B = 0x80.
- R11: Status register 6: bit 0 sets when vertical sync starts, and bit 1 sets when `underrun_i` is high while running. Writing 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R12: Mask register 7 resets to 2'b11, and a 1 blocks the matching bit. `irq_o` is the OR of the status bits whose mask bit is 0.
- R13: Control register 0 holds the mode in bits 1:0 (0 off, 1 normal, 2 test, 3 bars) and the raster enable in bit 14, and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| layer_valid_i | input | 1 | A layer covers the current pixel |
| layer_rgb_i | input | 24 | Layer colour for the current pixel |
| underrun_i | input | 1 | Pixel-fetch underrun event |
| pix_ce_o | output | 1 | Pixel clock enable |
| pix_fall_o | output | 1 | Launch data on falling pixel-clock edge |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | H_W | Active pixel column |
| pix_y_o | output | V_W | Active pixel line |
| rgb_o | output | 24 | Output colour |
| irq_o | output | 1 | Interrupt request |

## Verification
The timing is run with a divided pixel clock and then an undivided one, under each of the three display modes, so that both divider spacing and per-mode colour selection are compared against a behavioural model on every cycle. The layer-valid input toggles during normal mode, which separates background fill from layer pass-through. A horizontal timing register is rewritten in the middle of a frame, and the model only adopts the new value at the frame end, so an immediate update shows up as a line-length mismatch. Polarity inversion, an underrun pulse, a write-one-to-clear and mask changes separate the sync levels from the interrupt paths. The off and disabled states are both entered while all timing is programmed, so that idle outputs are shown to be gated.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [3:0] {
    RA_CTRL    = 4'd0,
    RA_BG      = 4'd1,
    RA_SIZE    = 4'd2,
    RA_HTIM    = 4'd3,
    RA_VTIM    = 4'd4,
    RA_POL     = 4'd5,
    RA_IRQ_ST  = 4'd6,
    RA_IRQ_MSK = 4'd7,
    RA_DIV     = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_TEST   = 2'd2,
    MODE_BARS   = 2'd3
  } op_mode_e;

  localparam int PORCH_W = 11;
  localparam int BPORCH_W = 10;
  localparam int LINE_W = 16;

  // layout matches the per-axis register bit positions
  typedef struct packed {
    logic [BPORCH_W-1:0] bp;
    logic [PORCH_W-1:0]  pw;
    logic [PORCH_W-1:0]  fp;
  } axis_tim_t;
endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import raster_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int XBLK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              load_i,
  input  logic [1:0]        status_i,
  output logic [31:0]       rdata_o,
  output op_mode_e          mode_o,
  output logic              ren_o,
  output logic [23:0]       bg_o,
  output logic              pol_h_o,
  output logic              pol_v_o,
  output logic              pol_fall_o,
  output logic [1:0]        mask_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [XBLK_W-1:0] xblk_o,
  output logic [LINE_W-1:0] lines_o,
  output axis_tim_t         htim_o,
  output axis_tim_t         vtim_o
);
  logic [DIV_W-1:0]  st_div;
  logic [XBLK_W-1:0] st_xblk;
  logic [LINE_W-1:0] st_lines;
  axis_tim_t         st_h, st_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_OFF;
      ren_o      <= 1'b0;
      bg_o       <= '0;
      pol_h_o    <= 1'b0;
      pol_v_o    <= 1'b0;
      pol_fall_o <= 1'b0;
      mask_o     <= 2'b11;
      st_div     <= '0;
      st_xblk    <= '0;
      st_lines   <= '0;
      st_h       <= '0;
      st_v       <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        RA_CTRL: begin
          mode_o <= op_mode_e'(wdata_i[1:0]);
          ren_o  <= wdata_i[14];
        end
        RA_BG:   bg_o <= wdata_i[23:0];
        RA_SIZE: begin
          st_lines <= wdata_i[31:16];
          st_xblk  <= wdata_i[XBLK_W-1:0];
        end
        RA_HTIM: st_h <= axis_tim_t'(wdata_i);
        RA_VTIM: st_v <= axis_tim_t'(wdata_i);
        RA_POL: begin
          pol_h_o    <= wdata_i[0];
          pol_v_o    <= wdata_i[1];
          pol_fall_o <= wdata_i[6];
        end
        RA_IRQ_MSK: mask_o <= wdata_i[1:0];
        RA_DIV:     st_div <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // active copy follows staged copy only at a frame boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o   <= '0;
      xblk_o  <= '0;
      lines_o <= '0;
      htim_o  <= '0;
      vtim_o  <= '0;
    end else if (load_i) begin
      div_o   <= st_div;
      xblk_o  <= st_xblk;
      lines_o <= st_lines;
      htim_o  <= st_h;
      vtim_o  <= st_v;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      RA_CTRL: begin
        rdata_o[1:0] = mode_o;
        rdata_o[14]  = ren_o;
      end
      RA_BG:   rdata_o[23:0] = bg_o;
      RA_SIZE: begin
        rdata_o[31:16]       = st_lines;
        rdata_o[XBLK_W-1:0]  = st_xblk;
      end
      RA_HTIM: rdata_o = st_h;
      RA_VTIM: rdata_o = st_v;
      RA_POL: begin
        rdata_o[0] = pol_h_o;
        rdata_o[1] = pol_v_o;
        rdata_o[6] = pol_fall_o;
      end
      RA_IRQ_ST:  rdata_o[1:0] = status_i;
      RA_IRQ_MSK: rdata_o[1:0] = mask_o;
      RA_DIV:     rdata_o[DIV_W-1:0] = st_div;
      default: ;
    endcase
  end
endmodule

// File: rtl/rt_axis.sv
module rt_axis
  import raster_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int ACT_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                step_i,
  input  logic [ACT_W-1:0]    act_i,
  input  axis_tim_t           tim_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                wrap_o,
  output logic                active_o,
  output logic                sync_o
);
  logic [CNT_W-1:0] end_act, end_fp, end_sync, total;
  logic             last;

  assign end_act  = CNT_W'(act_i);
  assign end_fp   = end_act + CNT_W'(tim_i.fp);
  assign end_sync = end_fp + CNT_W'(tim_i.pw);
  assign total    = end_sync + CNT_W'(tim_i.bp);
  assign last     = cnt_o == total - CNT_W'(1);

  assign wrap_o   = run_i && step_i && last;
  assign active_o = cnt_o < end_act;
  assign sync_o   = (cnt_o >= end_fp) && (cnt_o < end_sync);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (!run_i)  cnt_o <= '0;
    else if (step_i)  cnt_o <= last ? '0 : cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/rt_irq.sv
module rt_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       running_i,
  input  logic       vs_act_i,
  input  logic       underrun_i,
  input  logic [1:0] clr_i,
  input  logic [1:0] mask_i,
  output logic [1:0] status_o,
  output logic       irq_o
);
  logic       vs_q;
  logic [1:0] set;

  assign set = {running_i && underrun_i, vs_act_i && !vs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q     <= 1'b0;
      status_o <= '0;
    end else begin
      vs_q     <= vs_act_i;
      status_o <= (status_o & ~clr_i) | set;
    end
  end

  assign irq_o = |(status_o & ~mask_i);
endmodule

// File: rtl/rt_pixel.sv
module rt_pixel
  import raster_pkg::*;
#(
  parameter int XBLK_W = 8,
  parameter int H_W    = 14,
  parameter int V_W    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              step_i,
  input  logic              line_wrap_i,
  input  logic              h_act_i,
  input  logic              de_i,
  input  op_mode_e          mode_i,
  input  logic [XBLK_W-1:0] xblk_i,
  input  logic [H_W-1:0]    hcnt_i,
  input  logic [V_W-1:0]    vcnt_i,
  input  logic [23:0]       bg_i,
  input  logic              layer_valid_i,
  input  logic [23:0]       layer_rgb_i,
  output logic [23:0]       rgb_o
);
  localparam int BW_W = XBLK_W + 1;

  logic [BW_W-1:0] bar_w, bar_pos;
  logic [2:0]      bar_idx;
  logic [23:0]     bar_rgb;

  assign bar_w = {xblk_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bar_pos <= '0;
      bar_idx <= '0;
    end else if (!run_i || line_wrap_i) begin
      bar_pos <= '0;
      bar_idx <= '0;
    end else if (step_i && h_act_i) begin
      if (bar_pos == bar_w - BW_W'(1)) begin
        bar_pos <= '0;
        bar_idx <= bar_idx + 3'd1;
      end else begin
        bar_pos <= bar_pos + BW_W'(1);
      end
    end
  end

  // white, yellow, cyan, green, magenta, red, blue, black
  assign bar_rgb = {{8{~bar_idx[1]}}, {8{~bar_idx[2]}}, {8{~bar_idx[0]}}};

  always_comb begin
    rgb_o = '0;
    if (de_i) begin
      case (mode_i)
        MODE_NORMAL: rgb_o = layer_valid_i ? layer_rgb_i : bg_i;
        MODE_TEST:   rgb_o = {hcnt_i[7:0], vcnt_i[7:0], 8'h80};
        MODE_BARS:   rgb_o = bar_rgb;
        default:     rgb_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int XBLK_W = 8,
  localparam int ACT_W = XBLK_W + 4,
  localparam int H_W   = ((ACT_W > PORCH_W) ? ACT_W : PORCH_W) + 2,
  localparam int V_W   = LINE_W + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [3:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           layer_valid_i,
  input  logic [23:0]    layer_rgb_i,
  input  logic           underrun_i,
  output logic           pix_ce_o,
  output logic           pix_fall_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [H_W-1:0] pix_x_o,
  output logic [V_W-1:0] pix_y_o,
  output logic [23:0]    rgb_o,
  output logic           irq_o
);
  op_mode_e          mode;
  logic              ren, running, pol_h, pol_v, load, frame_end;
  logic [23:0]       bg;
  logic [1:0]        mask, status, st_clr;
  logic [DIV_W-1:0]  div_act, div_cnt;
  logic [XBLK_W-1:0] xblk_act;
  logic [LINE_W-1:0] lines_act;
  axis_tim_t         htim, vtim;
  logic [H_W-1:0]    h_cnt;
  logic [V_W-1:0]    v_cnt;
  logic              h_wrap, h_act, h_sync, v_wrap, v_act, v_sync;

  assign running   = ren && (mode != MODE_OFF);
  assign frame_end = v_wrap;
  assign load      = !running || frame_end;
  assign st_clr    = (reg_we_i && reg_addr_i == RA_IRQ_ST) ? reg_wdata_i[1:0] : 2'b00;

  rt_regs #(.DIV_W(DIV_W), .XBLK_W(XBLK_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .load_i(load), .status_i(status), .rdata_o(reg_rdata_o),
    .mode_o(mode), .ren_o(ren), .bg_o(bg),
    .pol_h_o(pol_h), .pol_v_o(pol_v), .pol_fall_o(pix_fall_o),
    .mask_o(mask), .div_o(div_act), .xblk_o(xblk_act), .lines_o(lines_act),
    .htim_o(htim), .vtim_o(vtim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_cnt <= '0;
    else if (!running)  div_cnt <= '0;
    else                div_cnt <= (div_cnt == div_act) ? '0 : div_cnt + DIV_W'(1);
  end

  assign pix_ce_o = running && (div_cnt == div_act);

  rt_axis #(.CNT_W(H_W), .ACT_W(ACT_W)) i_h_axis (
    .clk_i, .rst_ni, .run_i(running), .step_i(pix_ce_o),
    .act_i({xblk_act, 4'b0000}), .tim_i(htim),
    .cnt_o(h_cnt), .wrap_o(h_wrap), .active_o(h_act), .sync_o(h_sync)
  );

  rt_axis #(.CNT_W(V_W), .ACT_W(LINE_W)) i_v_axis (
    .clk_i, .rst_ni, .run_i(running), .step_i(h_wrap),
    .act_i(lines_act), .tim_i(vtim),
    .cnt_o(v_cnt), .wrap_o(v_wrap), .active_o(v_act), .sync_o(v_sync)
  );

  assign de_o    = running && h_act && v_act;
  assign hsync_o = (running && h_sync) ^ pol_h;
  assign vsync_o = (running && v_sync) ^ pol_v;
  assign pix_x_o = de_o ? h_cnt : '0;
  assign pix_y_o = de_o ? v_cnt : '0;

  rt_pixel #(.XBLK_W(XBLK_W), .H_W(H_W), .V_W(V_W)) i_pixel (
    .clk_i, .rst_ni, .run_i(running), .step_i(pix_ce_o), .line_wrap_i(h_wrap),
    .h_act_i(h_act), .de_i(de_o), .mode_i(mode), .xblk_i(xblk_act),
    .hcnt_i(h_cnt), .vcnt_i(v_cnt), .bg_i(bg),
    .layer_valid_i, .layer_rgb_i, .rgb_o
  );

  rt_irq i_irq (
    .clk_i, .rst_ni, .running_i(running), .vs_act_i(running && v_sync),
    .underrun_i, .clr_i(st_clr), .mask_i(mask), .status_o(status), .irq_o
  );
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int DIV_W  = 8,
  parameter int XBLK_W = 8,
  parameter int H_W    = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              running,
  input logic              de_o,
  input logic              pix_ce_o,
  input logic              hsync_o,
  input logic              pol_h,
  input logic [23:0]       rgb_o,
  input logic [DIV_W-1:0]  div_act,
  input logic [XBLK_W-1:0] xblk_act,
  input logic [H_W-1:0]    pix_x_o,
  input logic              irq_o,
  input logic [1:0]        mask,
  input logic [1:0]        status,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i
);
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> (!de_o && !pix_ce_o && rgb_o == 24'd0)); // R1
  AST_CE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && pix_ce_o && div_act != '0) |=> (!pix_ce_o || div_act == '0)); // R2
  AST_NO_SYNC_IN_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == pol_h)); // R3
  AST_X_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (pix_x_o < H_W'({xblk_act, 4'b0000}))); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == 2'b11) |-> !irq_o); // R12
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[1] && !(reg_we_i && reg_addr_i == 4'd6 && reg_wdata_i[1])) |=> status[1]); // R11
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.DIV_W(DIV_W), .XBLK_W(XBLK_W), .H_W(H_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .running(running), .de_o(de_o), .pix_ce_o(pix_ce_o),
  .hsync_o(hsync_o), .pol_h(pol_h), .rgb_o(rgb_o), .div_act(div_act), .xblk_act(xblk_act),
  .pix_x_o(pix_x_o), .irq_o(irq_o), .mask(mask), .status(status),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lv = 1'b0;
  logic [23:0] lrgb = '0;
  logic        urun = 1'b0;
  logic        ce, fall, hs, vs, de, irq;
  logic [13:0] px;
  logic [17:0] py;
  logic [23:0] rgb;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .layer_valid_i(lv), .layer_rgb_i(lrgb), .underrun_i(urun),
    .pix_ce_o(ce), .pix_fall_o(fall), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .pix_x_o(px), .pix_y_o(py), .rgb_o(rgb), .irq_o(irq)
  );

  // reference model state
  int m_mode, m_bg, hc, vc, dc;
  bit m_ren, m_polh, m_polv, m_fall, m_vsd;
  bit [1:0] m_mask, m_stat;
  int s_div, s_xblk, s_lines, s_hfp, s_hpw, s_hbp, s_vfp, s_vpw, s_vbp;
  int a_div, a_xblk, a_lines, a_hfp, a_hpw, a_hbp, a_vfp, a_vpw, a_vbp;
  int mw, htot, vtot;
  bit mrun, mce, mhl, mvl, mvsa, mload;
  bit [1:0] nstat;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_bg = 0; hc = 0; vc = 0; dc = 0;
      m_ren = 0; m_polh = 0; m_polv = 0; m_fall = 0; m_vsd = 0;
      m_mask = 2'b11; m_stat = 0;
      s_div = 0; s_xblk = 0; s_lines = 0; s_hfp = 0; s_hpw = 0; s_hbp = 0;
      s_vfp = 0; s_vpw = 0; s_vbp = 0;
      a_div = 0; a_xblk = 0; a_lines = 0; a_hfp = 0; a_hpw = 0; a_hbp = 0;
      a_vfp = 0; a_vpw = 0; a_vbp = 0;
    end else begin
      mrun = m_ren && m_mode != 0;
      mw = a_xblk * 16;
      htot = mw + a_hfp + a_hpw + a_hbp;
      vtot = a_lines + a_vfp + a_vpw + a_vbp;
      mce = mrun && dc == a_div;
      mhl = hc == htot - 1;
      mvl = vc == vtot - 1;
      mvsa = mrun && vc >= a_lines + a_vfp && vc < a_lines + a_vfp + a_vpw;
      mload = !mrun || (mce && mhl && mvl);
      nstat = m_stat;
      if (we && addr == 4'd6) nstat = nstat & ~wdata[1:0];
      if (mvsa && !m_vsd) nstat[0] = 1'b1;
      if (mrun && urun) nstat[1] = 1'b1;
      if (!mrun) begin
        dc = 0; hc = 0; vc = 0;
      end else begin
        if (mce) begin
          if (mhl) begin
            hc = 0;
            vc = mvl ? 0 : vc + 1;
          end else hc = hc + 1;
        end
        dc = (dc == a_div) ? 0 : dc + 1;
      end
      if (mload) begin
        a_div = s_div; a_xblk = s_xblk; a_lines = s_lines;
        a_hfp = s_hfp; a_hpw = s_hpw; a_hbp = s_hbp;
        a_vfp = s_vfp; a_vpw = s_vpw; a_vbp = s_vbp;
      end
      if (we) begin
        case (addr)
          4'd0: begin m_mode = int'(wdata[1:0]); m_ren = wdata[14]; end
          4'd1: m_bg = int'(wdata[23:0]);
          4'd2: begin s_lines = int'(wdata[31:16]); s_xblk = int'(wdata[7:0]); end
          4'd3: begin s_hbp = int'(wdata[31:22]); s_hpw = int'(wdata[21:11]); s_hfp = int'(wdata[10:0]); end
          4'd4: begin s_vbp = int'(wdata[31:22]); s_vpw = int'(wdata[21:11]); s_vfp = int'(wdata[10:0]); end
          4'd5: begin m_polh = wdata[0]; m_polv = wdata[1]; m_fall = wdata[6]; end
          4'd7: m_mask = wdata[1:0];
          4'd8: s_div = int'(wdata[7:0]);
          default: ;
        endcase
      end
      m_stat = nstat;
      m_vsd = mvsa;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    int w, idx, ergb;
    bit run, ede, ehs, evs;
    string ctag;
    run = m_ren && m_mode != 0;
    w = a_xblk * 16;
    ede = run && hc < w && vc < a_lines;
    ehs = (run && hc >= w + a_hfp && hc < w + a_hfp + a_hpw) ^ m_polh;
    evs = (run && vc >= a_lines + a_vfp && vc < a_lines + a_vfp + a_vpw) ^ m_polv;
    ergb = 0;
    ctag = run ? "R8" : "R1";
    if (ede) begin
      case (m_mode)
        1: ergb = lv ? int'(lrgb) : m_bg;
        2: begin ergb = ((hc & 255) << 16) | ((vc & 255) << 8) | 8'h80; ctag = "R10"; end
        3: begin
          idx = hc / (2 * a_xblk);
          ergb = ((((idx >> 1) & 1) != 0) ? 0 : 24'hFF0000) |
                 ((((idx >> 2) & 1) != 0) ? 0 : 24'h00FF00) |
                 (((idx & 1) != 0) ? 0 : 24'h0000FF);
          ctag = "R9";
        end
        default: ergb = 0;
      endcase
    end
    chk(run ? "R3 R5 R7 hsync" : "R1 hsync", hs, ehs);
    chk(run ? "R4 R5 vsync" : "R1 vsync", vs, evs);
    chk(run ? "R3 R6 de" : "R1 de", de, ede);
    chk("R3 pix_x", px, ede ? hc : 0);
    chk("R4 pix_y", py, ede ? vc : 0);
    chk(run ? "R2 pix_ce" : "R1 pix_ce", ce, run && dc == a_div);
    chk("R5 pix_fall", fall, m_fall);
    chk({ctag, " rgb"}, rgb, ergb);
    chk("R12 irq", irq, |(m_stat & ~m_mask));
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic run_cycles(input int n, input bit toggle_layer);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (toggle_layer) begin
        lv = i[3];
        lrgb = 24'(i * 7 + 24'h010203);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    rd("R12 mask reset", 4'd7, 32'h3);
    rd("R13 ctrl reset", 4'd0, 32'h0);
    // R6 field layout: 4 lines, 16 px wide; h fp2 pw3 bp1; v fp1 pw2 bp1
    wr(4'd2, {16'd4, 16'd1});
    wr(4'd3, (32'd1 << 22) | (32'd3 << 11) | 32'd2);
    wr(4'd4, (32'd1 << 22) | (32'd2 << 11) | 32'd1);
    wr(4'd8, 32'd1);
    wr(4'd1, 32'h123456);
    wr(4'd7, 32'h0);
    rd("R6 size readback", 4'd2, {16'd4, 16'd1});
    wr(4'd0, (32'd1 << 14) | 32'd1);
    rd("R13 ctrl readback", 4'd0, (32'd1 << 14) | 32'd1);
    run_cycles(800, 1'b1);
    // R7: mid-frame rewrite of horizontal timing
    wr(4'd3, (32'd2 << 22) | (32'd3 << 11) | 32'd4);
    rd("R7 staged readback", 4'd3, (32'd2 << 22) | (32'd3 << 11) | 32'd4);
    run_cycles(900, 1'b1);
    // R11: clear, then underrun pulse
    wr(4'd6, 32'h3);
    @(posedge clk); #1 urun = 1'b1;
    @(posedge clk); #1 urun = 1'b0;
    @(negedge clk);
    chk("R11 underrun status", rdata, {30'd0, m_stat});
    rd("R11 status", 4'd6, {30'd0, m_stat});
    wr(4'd6, 32'h2);
    rd("R11 w1c", 4'd6, {30'd0, m_stat});
    wr(4'd7, 32'h3);
    run_cycles(50, 1'b0);
    wr(4'd7, 32'h1);
    // R5 inverted polarities
    wr(4'd5, 32'h43);
    run_cycles(400, 1'b1);
    // R9 bars with wider blocks and undivided clock
    wr(4'd2, {16'd3, 16'd2});
    wr(4'd8, 32'd0);
    wr(4'd0, (32'd1 << 14) | 32'd3);
    run_cycles(1200, 1'b0);
    // R10 test ramp
    wr(4'd0, (32'd1 << 14) | 32'd2);
    run_cycles(600, 1'b0);
    // R1 disabled and off
    wr(4'd0, 32'd1);
    run_cycles(100, 1'b1);
    wr(4'd0, (32'd1 << 14));
    run_cycles(100, 1'b1);
    wr(4'd5, 32'h0);
    run_cycles(20, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule